// File: doc/BRIEF.md
# Sigma-Delta Sinc3 Decimation Filter

This block turns the single-bit output stream of an external sigma-delta modulator into signed 16-bit current samples for a motor control loop. The modulator is clocked by the same clock that runs this block, so each clock edge takes in one modulator bit. A bit of 1 counts as one and a bit of 0 counts as zero. The stream passes through three cascaded integrators. One value in every M is kept and the rest are dropped. The kept values then pass through three cascaded differentiators. No multipliers are used anywhere. All integrator arithmetic wraps around, and the differentiators still recover the exact result.

Each conversion begins with a trigger pulse that the PWM timing logic raises during a quiet part of the switching cycle. The pulse clears every filter register and the decimation counter. It also captures the decimation select: M=128 when the select is 0 and M=64 when it is 1. The filter needs three full output periods of history before its result is exact, so results appear only from the fourth decimation point after the trigger. Each result is processed in four steps. The midscale value M³/2 is removed, the value is scaled so that full scale reaches the 16-bit limits, a programmable offset is subtracted, and the result is saturated. It is then presented together with a one-cycle valid pulse, which can also serve as the data-ready interrupt.

Top module: `sdm_sinc3_decim`

## Requirements
- R1: After reset, and until the first trigger, out_valid stays 0 and out_data reads 0.
- R2: With offset 0, a stream of all ones gives out_data = 32767 (saturated), and a stream of all zeros gives -32768.
- R3: For an input of period M with k ones per period, each result equals (k·2^(2L) − 2^(3L−1)) / 2^(3L−16) − offset, where L = log2 M. For M=128 this is 512·k − 32768, and for M=64 it is 1024·k − 32768.
- R4: m_sel = 0 selects M = 128 and m_sel = 1 selects M = 64. The value is captured on the trigger edge, and a change of m_sel during a conversion has no effect on the period or on the values of that conversion.
- R5: The first out_valid pulse comes exactly 4·M clocks after the edge that samples the trigger. Further pulses follow every M clocks, each lasting one cycle.
- R6: A trigger in the middle of a conversion drops out_valid in the next cycle. No new result appears until 4·M clocks after that trigger.
- R7: The signed offset is subtracted in output LSB units, and the result saturates to the range [-32768, 32767] rather than wrapping.
- R8: out_data holds its value between out_valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator and filter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion trigger from the PWM timing logic; clears the filter and captures m_sel |
| m_sel | input | 1 | Decimation select: 0 gives M=128, 1 gives M=64 |
| bit_in | input | 1 | Modulator bitstream, one bit per clock |
| offset | input | 16 | Signed zero-current correction, in output LSBs |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 16 | Signed corrected result |

## Verification
The filter is driven with streams of period M whose duty k sweeps from all zeros to all ones in both decimation modes. Each duty maps to a distinct output level, so a stage that is missing, doubled or has the wrong width shows up as a slope or offset error on the output line. The extremes of the sweep, together with large offsets of either sign, push the result into both saturation rails. Back-to-back triggers during running conversions test the clearing. Toggling the select during a conversion separates a select that is captured at the trigger from one that is followed live.

// File: rtl/sdm_sinc3_decim.sv
module sdm_sinc3_decim #(
  parameter int LOG2_M_SLOW = 7,
  parameter int LOG2_M_FAST = 6,
  parameter int OUT_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    m_sel,
  input  logic                    bit_in,
  input  logic signed [OUT_W-1:0] offset,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int ACC_W  = 1 + 3 * LOG2_M_SLOW;
  localparam int CNT_W  = LOG2_M_SLOW;
  localparam int CEN_W  = ACC_W + 1;
  localparam int SUB_W  = (CEN_W > OUT_W ? CEN_W : OUT_W) + 1;
  localparam int SH_SLOW = 3 * LOG2_M_SLOW - OUT_W;
  localparam int SH_FAST = 3 * LOG2_M_FAST - OUT_W;
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'((1 << LOG2_M_SLOW) - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'((1 << LOG2_M_FAST) - 1);
  localparam logic signed [CEN_W-1:0] MID_SLOW = CEN_W'(1) <<< (3 * LOG2_M_SLOW - 1);
  localparam logic signed [CEN_W-1:0] MID_FAST = CEN_W'(1) <<< (3 * LOG2_M_FAST - 1);
  localparam logic signed [SUB_W-1:0] MAXV = SUB_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUB_W-1:0] MINV = -MAXV - SUB_W'(1);

  logic             running, m_lat;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       settle;
  logic [ACC_W-1:0] i1, i2, i3, z1, z2, z3;
  logic [ACC_W-1:0] d1, d2, d3;
  logic             last, strobe;
  logic signed [CEN_W-1:0] centered, scaled;
  logic signed [SUB_W-1:0] corrected;
  logic signed [OUT_W-1:0] clipped;

  assign last   = m_lat ? (cnt == LAST_FAST) : (cnt == LAST_SLOW);
  assign strobe = running && last;

  assign d1 = i3 - z1;
  assign d2 = d1 - z2;
  assign d3 = d2 - z3;

  assign centered  = $signed({1'b0, d3}) - (m_lat ? MID_FAST : MID_SLOW);
  assign scaled    = m_lat ? (centered >>> SH_FAST) : (centered >>> SH_SLOW);
  assign corrected = SUB_W'(scaled) - SUB_W'(offset);

  always_comb begin
    if (corrected > MAXV)      clipped = MAXV[OUT_W-1:0];
    else if (corrected < MINV) clipped = MINV[OUT_W-1:0];
    else                       clipped = corrected[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      m_lat     <= 1'b0;
      cnt       <= '0;
      settle    <= '0;
      i1        <= '0;
      i2        <= '0;
      i3        <= '0;
      z1        <= '0;
      z2        <= '0;
      z3        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (start) begin
      running   <= 1'b1;
      m_lat     <= m_sel;
      cnt       <= '0;
      settle    <= '0;
      i1        <= '0;
      i2        <= '0;
      i3        <= '0;
      z1        <= '0;
      z2        <= '0;
      z3        <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (running) begin
        i1  <= i1 + ACC_W'(bit_in);
        i2  <= i2 + i1;
        i3  <= i3 + i2;
        cnt <= last ? '0 : cnt + 1'b1;
      end
      if (strobe) begin
        z1 <= i3;
        z2 <= d1;
        z3 <= d2;
        if (settle == 2'd3) begin
          out_valid <= 1'b1;
          out_data  <= clipped;
        end else begin
          settle <= settle + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/sdm_sinc3_decim_chk.sv
module sdm_sinc3_decim_chk #(
  parameter int LOG2_M_SLOW = 7,
  parameter int LOG2_M_FAST = 6,
  parameter int OUT_W       = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    m_sel,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);

  localparam int M_SLOW = 1 << LOG2_M_SLOW;
  localparam int M_FAST = 1 << LOG2_M_FAST;

  logic [31:0] since;
  logic        mlat, seen;
  int          m_cur;

  assign m_cur = mlat ? M_FAST : M_SLOW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      mlat  <= 1'b0;
      seen  <= 1'b0;
    end else if (start) begin
      since <= '0;
      mlat  <= m_sel;
      seen  <= 1'b1;
    end else if (since != 32'hFFFF_FFFF) begin
      since <= since + 32'd1;
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (!out_valid && out_data == '0));

  p_valid_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen && since >= 32'(4 * m_cur) && (since % 32'(m_cur)) == 0));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (out_valid || $stable(out_data)));

endmodule

bind sdm_sinc3_decim sdm_sinc3_decim_chk #(
  .LOG2_M_SLOW(LOG2_M_SLOW),
  .LOG2_M_FAST(LOG2_M_FAST),
  .OUT_W(OUT_W)
) u_chk (.*);

// File: tb/sdm_sinc3_decim_tb.sv
module sdm_sinc3_decim_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               m_sel = 1'b0;
  logic               bit_in = 1'b0;
  logic signed [15:0] offset = '0;
  logic               out_valid;
  logic signed [15:0] out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdm_sinc3_decim u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .m_sel(m_sel),
    .bit_in(bit_in), .offset(offset), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int expect_val(bit ms, int k, int off);
    int L = ms ? 6 : 7;
    longint v;
    v = (longint'(k) <<< (2 * L)) - (longint'(1) <<< (3 * L - 1));
    v = v >>> (3 * L - 16);
    v = v - off;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return int'(v);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(bit ms, int k, int off, bit toggle, string req);
    int m = ms ? 64 : 128;
    int p = 0;
    int bad_timing = 0;
    int bad_value = 0;
    int last_act = 0;
    int exp = expect_val(ms, k, off);
    @(negedge clk);
    m_sel  = ms;
    offset = 16'(off);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(out_valid == 1'b0, "R6", int'(out_valid), 0);
    for (int e = 1; e <= 6 * m; e++) begin
      bit_in = (p < k);
      p = (p + 1) % m;
      if (toggle && e == 2 * m) m_sel = ~ms;
      @(negedge clk);
      if (out_valid != ((e >= 4 * m) && (e % m == 0))) bad_timing++;
      if (out_valid && int'(out_data) != exp) begin
        bad_value++;
        last_act = int'(out_data);
      end
      if (out_valid) checks++;
    end
    checks--;
    check(bad_timing == 0, "R5 timing", bad_timing, 0);
    check(bad_value == 0, req, last_act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      bit_in = i[0];
      @(negedge clk);
      if (i == 19) begin
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_data == 16'sd0, "R1 data", int'(out_data), 0);
      end
    end
    // R2 extremes
    run(1'b0, 128, 0, 1'b0, "R2 ones M128");
    run(1'b0, 0, 0, 1'b0, "R2 zeros M128");
    run(1'b1, 64, 0, 1'b0, "R2 ones M64");
    run(1'b1, 0, 0, 1'b0, "R2 zeros M64");
    // R3 duty sweeps, both modes (R4 mode selection)
    for (int k = 0; k <= 128; k += 4) run(1'b0, k, 0, 1'b0, "R3 R4 sweep M128");
    for (int k = 0; k <= 64; k += 2) run(1'b1, k, 0, 1'b0, "R3 R4 sweep M64");
    run(1'b0, 127, 0, 1'b0, "R3 k127");
    run(1'b1, 63, 0, 1'b0, "R3 k63");
    // R4 select changed mid-conversion is ignored
    run(1'b0, 40, 0, 1'b1, "R4 toggle M128");
    run(1'b1, 20, 0, 1'b1, "R4 toggle M64");
    // R7 offset and saturation
    run(1'b0, 64, 1000, 1'b0, "R7 offset");
    run(1'b0, 128, -5, 1'b0, "R7 sat high");
    run(1'b0, 0, 100, 1'b0, "R7 sat low");
    run(1'b0, 120, -200, 1'b0, "R7 neg offset");
    run(1'b1, 10, 300, 1'b0, "R7 offset M64");
    // R8 hold between pulses
    begin
      logic signed [15:0] held;
      @(negedge clk);
      held = out_data;
      bit_in = 1'b1;
      offset = 16'sd7;
      repeat (30) @(negedge clk);
      check(out_data == held, "R8 hold", int'(out_data), int'(held));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule